// File: doc/BRIEF.md
# Data Address Translation Buffer

This block translates the virtual address of a load or store into a physical address. A request carries the address, a store flag, a flag that bypasses translation, the current privilege mode, the current address-space number and a two-bit superpage control. The block first checks that the address is well formed. It then either maps a kernel superpage window straight through, or searches a fully associative table of page entries by page number and address-space number. The result comes back one cycle later. It holds a physical address, hit and miss flags, a fault code and memory-management status bits.

Entries are written through an insert port at the slot chosen by a round-robin replacement pointer. A flush input drops every entry at once. An indexed-read port returns the entry under the pointer as a 64-bit word. A read only moves the pointer when it is not speculative, so a speculative path leaves replacement order untouched. Eight counters track accesses, hits, misses and access violations, with separate counters for loads and stores. A miss is only reported. Refilling the table is left to the requester.

Top module: `dxlate_unit`

## Requirements
- R1: With the bypass flag set, the response address equals the request address exactly. Hit, miss, fault and status are all zero, and no counter moves.
- R2: An address is valid only when bits [63:42] are all ones or all zeros. An invalid address gives fault code 2 and status BADVA|ACV, plus WR for a store. This check is made before the superpage test. Status bits are WR=bit0, ACV=bit1, FONR=bit2, BADVA=bit3.
- R3: The superpage window applies when control bit 1 is set and VA[42:41]=2'b10. In kernel mode (mode code 0) the result is address VA[39:0] zero-extended, with no hit, no miss and no fault.
- R4: A superpage access in any mode other than kernel gives fault code 1 and status ACV, plus WR for a store. Mode codes are 0 kernel, 1 executive, 2 supervisor, 3 user.
- R5: A valid entry whose page number equals VA[42:13] and whose address-space number equals the request's gives a hit when permitted. The address is then {page frame, VA[12:0]}. If several entries match, the lowest slot wins.
- R6: When no entry matches, the response is a miss with fault code 0 and status 0.
- R7: A load is refused when bit [mode] of the entry's read-enable mask is clear. It then gives fault code 1, status ACV, and FONR when the entry's fault-on-read flag is set.
- R8: A store is refused when bit [mode] of the entry's write-enable mask is clear. It then gives fault code 1 and status ACV|WR.
- R9: Every translated request (bypass flag clear) bumps the access counter of its type. A permitted table hit bumps the hit counter, a miss bumps the miss counter, and any nonzero fault code bumps the violation counter.
- R10: An insert writes the slot under the pointer, marks it valid and advances the pointer, wrapping after the last slot. A flush invalidates every slot in one cycle and overrides an insert in the same cycle.
- R11: The read word holds the page frame of the slot under the pointer in bits [58:32] and its read-enable mask in bits [11:8], with all other bits zero. After a read with the speculative flag clear, the pointer advances by one. A speculative read leaves it unchanged.
- R12: The response is registered, so it is valid exactly one cycle after a request. It is zero when there was no request. After reset, all counters and the read word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_va | input | 64 | Virtual address |
| req_wr | input | 1 | Store when set |
| req_phys | input | 1 | Bypass translation |
| req_mode | input | 2 | Privilege mode |
| req_asn | input | 8 | Address-space number |
| req_spe | input | 2 | Superpage control |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 64 | Physical address |
| rsp_hit | output | 1 | Table hit |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 2 | 0 none, 1 violation, 2 bad address |
| rsp_stat | output | 4 | Status bits |
| ins_en | input | 1 | Insert entry |
| ins_vpn | input | 30 | Page number |
| ins_asn | input | 8 | Address-space number |
| ins_ppn | input | 27 | Page frame |
| ins_re | input | 4 | Read-enable mask per mode |
| ins_we | input | 4 | Write-enable mask per mode |
| ins_fonr | input | 1 | Fault-on-read flag |
| flush | input | 1 | Invalidate all entries |
| rd_en | input | 1 | Indexed read strobe |
| rd_spec | input | 1 | Read is speculative |
| rd_data | output | 64 | Entry word under pointer |
| cnt_rd_acc | output | CNT_W | Load accesses |
| cnt_rd_hit | output | CNT_W | Load hits |
| cnt_rd_miss | output | CNT_W | Load misses |
| cnt_rd_acv | output | CNT_W | Load violations |
| cnt_wr_acc | output | CNT_W | Store accesses |
| cnt_wr_hit | output | CNT_W | Store hits |
| cnt_wr_miss | output | CNT_W | Store misses |
| cnt_wr_acv | output | CNT_W | Store violations |

## Verification
Two addresses tell the check order apart. One is malformed but carries the superpage tag bits, so it must take the bad-address path; the other is well formed and sits in the window. Each is tried as a load and as a store, in kernel and in other modes, and with the superpage control bit cleared, which must fall through to a table miss. Table entries share a page number but differ in address-space number and permission masks. This separates hits, misses and both permission faults, with and without the fault-on-read flag. Speculative reads, non-speculative reads, a flush coinciding with an insert, and a full wrap of the pointer check replacement order through the read word.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int VA_W    = 64;
  localparam int IMPL_VA = 43;
  localparam int PA_W    = 40;
  localparam int PG_W    = 13;
  localparam int VPN_W   = IMPL_VA - PG_W;
  localparam int PPN_W   = PA_W - PG_W;
  localparam int ASN_W   = 8;
  localparam int NMODE   = 4;
  localparam int STAT_W  = 4;
  localparam int WORD_W  = 64;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_BADVA = 3;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0, MODE_EXEC = 2'd1, MODE_SUPV = 2'd2, MODE_USER = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_ACV = 2'd1, FLT_BADVA = 2'd2
  } fault_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [ASN_W-1:0] asn;
    logic [PPN_W-1:0] ppn;
    logic [NMODE-1:0] re;
    logic [NMODE-1:0] we;
    logic             fonr;
  } pte_t;

  // upper bits must be a sign extension of the top implemented bit
  function automatic logic va_ok(input logic [VA_W-1:0] va);
    logic [VA_W-IMPL_VA:0] hi;
    hi = va[VA_W-1:IMPL_VA-1];
    return (&hi) | ~(|hi);
  endfunction

  function automatic logic sp_sel(input logic [VA_W-1:0] va, input logic [1:0] spe);
    return spe[1] && (va[IMPL_VA-1 -: 2] == 2'b10);
  endfunction

  function automatic logic [VA_W-1:0] sp_pa(input logic [VA_W-1:0] va);
    return {{(VA_W-PA_W){1'b0}}, va[PA_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] tbl_pa(input logic [PPN_W-1:0] ppn,
                                             input logic [VA_W-1:0] va);
    return {{(VA_W-PA_W){1'b0}}, ppn, va[PG_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] pte_word(input logic [PPN_W-1:0] ppn,
                                                 input logic [NMODE-1:0] re);
    logic [WORD_W-1:0] w;
    w = '0;
    w[32 +: PPN_W] = ppn;
    w[8 +: NMODE]  = re;
    return w;
  endfunction
endpackage

// File: rtl/dxl_table.sv
module dxl_table import dxl_pkg::*; #(
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic [ASN_W-1:0]  look_asn,
  input  logic              ins_en,
  input  pte_t              ins_pte,
  input  logic              flush,
  input  logic              rd_en,
  input  logic              rd_spec,
  output logic              hit_any,
  output logic [PPN_W-1:0]  hit_ppn,
  output logic [NMODE-1:0]  hit_re,
  output logic [NMODE-1:0]  hit_we,
  output logic              hit_fonr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hitv;
  pte_t               ent [ENTRIES];
  logic [PTR_W-1:0]   ptr, ptr_nxt;
  logic               adv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitv[g] = vld[g] && (ent[g].vpn == look_vpn) && (ent[g].asn == look_asn);
  end

  // lowest matching slot wins: scan downward so the last assignment is lowest
  always_comb begin
    hit_ppn  = '0;
    hit_re   = '0;
    hit_we   = '0;
    hit_fonr = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitv[i]) begin
        hit_ppn  = ent[i].ppn;
        hit_re   = ent[i].re;
        hit_we   = ent[i].we;
        hit_fonr = ent[i].fonr;
      end
    end
  end
  assign hit_any = |hitv;
  assign rd_word = pte_word(ent[ptr].ppn, ent[ptr].re);

  assign adv     = (ins_en && !flush) || (rd_en && !rd_spec);
  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else begin
      if (flush) begin
        vld <= '0;
      end else if (ins_en) begin
        ent[ptr] <= ins_pte;
        vld[ptr] <= 1'b1;
      end
      if (adv) ptr <= ptr_nxt;
    end
  end

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit_any);
  assert_spec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_spec && !ins_en) |=> $stable(ptr));
  assert_read_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_spec) |=>
      (ptr == (($past(ptr) == LAST) ? PTR_W'(0) : $past(ptr) + 1'b1)));
endmodule

// File: rtl/dxl_judge.sv
module dxl_judge import dxl_pkg::*; (
  input  logic              phys,
  input  logic [VA_W-1:0]   va,
  input  logic              wr,
  input  logic [1:0]        mode,
  input  logic [1:0]        spe,
  input  logic              match,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [NMODE-1:0]  re,
  input  logic [NMODE-1:0]  we,
  input  logic              fonr,
  output logic [VA_W-1:0]   pa,
  output logic              hit,
  output logic              miss,
  output fault_e            fault,
  output logic [STAT_W-1:0] stat
);
  always_comb begin
    pa    = '0;
    hit   = 1'b0;
    miss  = 1'b0;
    fault = FLT_NONE;
    stat  = '0;
    if (phys) begin
      pa = va;
    end else if (!va_ok(va)) begin
      fault           = FLT_BADVA;
      stat[ST_BADVA]  = 1'b1;
      stat[ST_ACV]    = 1'b1;
      stat[ST_WR]     = wr;
    end else if (sp_sel(va, spe)) begin
      if (mode != MODE_KERN) begin
        fault        = FLT_ACV;
        stat[ST_ACV] = 1'b1;
        stat[ST_WR]  = wr;
      end else begin
        pa = sp_pa(va);
      end
    end else if (!match) begin
      miss = 1'b1;
    end else if (wr) begin
      if (!we[mode]) begin
        fault        = FLT_ACV;
        stat[ST_ACV] = 1'b1;
        stat[ST_WR]  = 1'b1;
      end else begin
        hit = 1'b1;
        pa  = tbl_pa(ppn, va);
      end
    end else if (!re[mode]) begin
      fault         = FLT_ACV;
      stat[ST_ACV]  = 1'b1;
      stat[ST_FONR] = fonr;
    end else begin
      hit = 1'b1;
      pa  = tbl_pa(ppn, va);
    end
  end
endmodule

// File: rtl/dxl_stats.sv
module dxl_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_en,
  input  logic             ev_wr,
  input  logic             ev_hit,
  input  logic             ev_miss,
  input  logic             ev_flt,
  output logic [8*CNT_W-1:0] cnt_flat
);
  localparam int NEV = 8;
  logic [NEV-1:0] ev;
  logic [3:0]     kind;

  assign kind = {ev_flt, ev_miss, ev_hit, 1'b1};
  assign ev   = {({4{ev_en && ev_wr}} & kind), ({4{ev_en && !ev_wr}} & kind)};

  for (genvar g = 0; g < NEV; g++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     c <= '0;
      else if (ev[g]) c <= c + 1'b1;
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = c;
  end

  assert_hit_is_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_flat[CNT_W +: CNT_W] != $past(cnt_flat[CNT_W +: CNT_W])) |->
      (cnt_flat[0 +: CNT_W] != $past(cnt_flat[0 +: CNT_W])));
  assert_hit_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en |-> !(ev_hit && ev_flt));
endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit import dxl_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_va,
  input  logic                req_wr,
  input  logic                req_phys,
  input  logic [1:0]          req_mode,
  input  logic [ASN_W-1:0]    req_asn,
  input  logic [1:0]          req_spe,
  output logic                rsp_valid,
  output logic [VA_W-1:0]     rsp_pa,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [1:0]          rsp_fault,
  output logic [STAT_W-1:0]   rsp_stat,
  input  logic                ins_en,
  input  logic [VPN_W-1:0]    ins_vpn,
  input  logic [ASN_W-1:0]    ins_asn,
  input  logic [PPN_W-1:0]    ins_ppn,
  input  logic [NMODE-1:0]    ins_re,
  input  logic [NMODE-1:0]    ins_we,
  input  logic                ins_fonr,
  input  logic                flush,
  input  logic                rd_en,
  input  logic                rd_spec,
  output logic [WORD_W-1:0]   rd_data,
  output logic [CNT_W-1:0]    cnt_rd_acc,
  output logic [CNT_W-1:0]    cnt_rd_hit,
  output logic [CNT_W-1:0]    cnt_rd_miss,
  output logic [CNT_W-1:0]    cnt_rd_acv,
  output logic [CNT_W-1:0]    cnt_wr_acc,
  output logic [CNT_W-1:0]    cnt_wr_hit,
  output logic [CNT_W-1:0]    cnt_wr_miss,
  output logic [CNT_W-1:0]    cnt_wr_acv
);
  pte_t               ins_pte;
  logic               t_hit;
  logic [PPN_W-1:0]   t_ppn;
  logic [NMODE-1:0]   t_re, t_we;
  logic               t_fonr;
  logic [VA_W-1:0]    j_pa;
  logic               j_hit, j_miss;
  fault_e             j_flt;
  logic [STAT_W-1:0]  j_stat;
  logic               xl_event;
  logic [8*CNT_W-1:0] cnt_flat;

  assign ins_pte = '{vpn: ins_vpn, asn: ins_asn, ppn: ins_ppn,
                     re: ins_re, we: ins_we, fonr: ins_fonr};

  dxl_table #(.ENTRIES(ENTRIES)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .look_vpn(req_va[IMPL_VA-1:PG_W]), .look_asn(req_asn),
    .ins_en(ins_en), .ins_pte(ins_pte), .flush(flush),
    .rd_en(rd_en), .rd_spec(rd_spec),
    .hit_any(t_hit), .hit_ppn(t_ppn), .hit_re(t_re), .hit_we(t_we),
    .hit_fonr(t_fonr), .rd_word(rd_data)
  );

  dxl_judge u_judge (
    .phys(req_phys), .va(req_va), .wr(req_wr), .mode(req_mode), .spe(req_spe),
    .match(t_hit), .ppn(t_ppn), .re(t_re), .we(t_we), .fonr(t_fonr),
    .pa(j_pa), .hit(j_hit), .miss(j_miss), .fault(j_flt), .stat(j_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= '0;
      rsp_stat  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_pa    <= req_valid ? j_pa : '0;
      rsp_hit   <= req_valid && j_hit;
      rsp_miss  <= req_valid && j_miss;
      rsp_fault <= req_valid ? j_flt : FLT_NONE;
      rsp_stat  <= req_valid ? j_stat : '0;
    end
  end

  assign xl_event = req_valid && !req_phys;

  dxl_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .ev_en(xl_event), .ev_wr(req_wr),
    .ev_hit(j_hit), .ev_miss(j_miss), .ev_flt(j_flt != FLT_NONE),
    .cnt_flat(cnt_flat)
  );

  assign cnt_rd_acc  = cnt_flat[0*CNT_W +: CNT_W];
  assign cnt_rd_hit  = cnt_flat[1*CNT_W +: CNT_W];
  assign cnt_rd_miss = cnt_flat[2*CNT_W +: CNT_W];
  assign cnt_rd_acv  = cnt_flat[3*CNT_W +: CNT_W];
  assign cnt_wr_acc  = cnt_flat[4*CNT_W +: CNT_W];
  assign cnt_wr_hit  = cnt_flat[5*CNT_W +: CNT_W];
  assign cnt_wr_miss = cnt_flat[6*CNT_W +: CNT_W];
  assign cnt_wr_acv  = cnt_flat[7*CNT_W +: CNT_W];

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_phys) |=>
      (rsp_pa == $past(req_va) && !rsp_hit && !rsp_miss && rsp_fault == 2'd0));
  assert_badva_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == 2'd2) |-> (rsp_stat[ST_BADVA] && rsp_stat[ST_ACV]));
  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_fault == 2'd0 && rsp_stat == '0));
  assert_fonr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stat[ST_FONR] |-> (rsp_fault == 2'd1 && !rsp_stat[ST_WR]));
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/dxlate_unit_tb.sv
`timescale 1ns/1ps
module dxlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wr, req_phys;
  logic [63:0] req_va;
  logic [1:0]  req_mode, req_spe;
  logic [7:0]  req_asn;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [63:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_stat;
  logic        ins_en, ins_fonr, flush, rd_en, rd_spec;
  logic [29:0] ins_vpn;
  logic [7:0]  ins_asn;
  logic [26:0] ins_ppn;
  logic [3:0]  ins_re, ins_we;
  logic [63:0] rd_data;
  logic [31:0] got [8];

  always #10 clk = ~clk;

  dxlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_wr(req_wr), .req_phys(req_phys), .req_mode(req_mode),
    .req_asn(req_asn), .req_spe(req_spe), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_stat(rsp_stat), .ins_en(ins_en),
    .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_ppn(ins_ppn),
    .ins_re(ins_re), .ins_we(ins_we), .ins_fonr(ins_fonr), .flush(flush),
    .rd_en(rd_en), .rd_spec(rd_spec), .rd_data(rd_data),
    .cnt_rd_acc(got[0]), .cnt_rd_hit(got[1]), .cnt_rd_miss(got[2]),
    .cnt_rd_acv(got[3]), .cnt_wr_acc(got[4]), .cnt_wr_hit(got[5]),
    .cnt_wr_miss(got[6]), .cnt_wr_acv(got[7])
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  bit          mv   [64];
  logic [29:0] mvpn [64];
  logic [7:0]  masn [64];
  logic [26:0] mppn [64];
  logic [3:0]  mre  [64];
  logic [3:0]  mwe  [64];
  bit          mfo  [64];
  int          mptr;
  int          ecnt [8];

  logic        e_valid, e_hit, e_miss;
  logic [63:0] e_pa;
  int          e_flt, e_stat;
  string       e_tag;

  task automatic chkv(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_wr = 0; req_phys = 0; req_va = '0;
    req_mode = 0; req_asn = 0; req_spe = 0;
    ins_en = 0; ins_vpn = '0; ins_asn = '0; ins_ppn = '0;
    ins_re = '0; ins_we = '0; ins_fonr = 0;
    flush = 0; rd_en = 0; rd_spec = 0;
  endtask

  task automatic eval();
    logic [63:0] v;
    logic [63:0] upper;
    int idx;
    v = req_va;
    e_valid = req_valid; e_hit = 0; e_miss = 0; e_pa = '0;
    e_flt = 0; e_stat = 0; e_tag = "R12";
    if (!req_valid) return;
    if (req_phys) begin
      e_tag = "R1"; e_pa = v; return;
    end
    upper = v >> 42;
    if (!(upper == 64'd0 || upper == 64'h3F_FFFF)) begin
      e_tag = "R2"; e_flt = 2; e_stat = 8 + 2 + (req_wr ? 1 : 0);
    end else if (req_spe[1] && v[42] && !v[41]) begin
      if (req_mode != 0) begin
        e_tag = "R4"; e_flt = 1; e_stat = 2 + (req_wr ? 1 : 0);
      end else begin
        e_tag = "R3"; e_pa = v & 64'hFF_FFFF_FFFF;
      end
    end else begin
      idx = -1;
      for (int i = 0; i < 64; i++)
        if (idx < 0 && mv[i] && mvpn[i] == v[42:13] && masn[i] == req_asn) idx = i;
      if (idx < 0) begin
        e_tag = "R6"; e_miss = 1;
      end else if (req_wr && !mwe[idx][req_mode]) begin
        e_tag = "R8"; e_flt = 1; e_stat = 3;
      end else if (!req_wr && !mre[idx][req_mode]) begin
        e_tag = "R7"; e_flt = 1; e_stat = 2 + (mfo[idx] ? 4 : 0);
      end else begin
        e_tag = "R5"; e_hit = 1;
        e_pa = (64'(mppn[idx]) << 13) | 64'(v[12:0]);
      end
    end
    begin
      int b;
      b = req_wr ? 4 : 0;
      ecnt[b]++;
      if (e_hit) ecnt[b+1]++;
      if (e_miss) ecnt[b+2]++;
      if (e_flt != 0) ecnt[b+3]++;
    end
  endtask

  task automatic tick();
    logic [63:0] ew;
    ew = (64'(mppn[mptr]) << 32) | (64'(mre[mptr]) << 8);
    chkv("R11 read word", rd_data, ew);
    eval();
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < 64; i++) mv[i] = 0;
    end else if (ins_en) begin
      mv[mptr] = 1; mvpn[mptr] = ins_vpn; masn[mptr] = ins_asn;
      mppn[mptr] = ins_ppn; mre[mptr] = ins_re; mwe[mptr] = ins_we;
      mfo[mptr] = ins_fonr;
    end
    if ((ins_en && !flush) || (rd_en && !rd_spec)) mptr = (mptr + 1) % 64;
    @(negedge clk);
    chkv("R12 valid", 64'(rsp_valid), 64'(e_valid));
    chkv(e_tag, rsp_pa, e_pa);
    chkv(e_tag, 64'(rsp_hit), 64'(e_hit));
    chkv(e_tag, 64'(rsp_miss), 64'(e_miss));
    chkv(e_tag, 64'(rsp_fault), 64'(e_flt));
    chkv(e_tag, 64'(rsp_stat), 64'(e_stat));
    for (int i = 0; i < 8; i++) chkv("R9 counter", 64'(got[i]), 64'(ecnt[i]));
  endtask

  task automatic rq(input logic [63:0] va, input bit wr, input bit ph,
                    input logic [1:0] md, input logic [7:0] asn, input logic [1:0] spe);
    idle();
    req_valid = 1; req_va = va; req_wr = wr; req_phys = ph;
    req_mode = md; req_asn = asn; req_spe = spe;
    tick();
  endtask

  task automatic put(input logic [63:0] va, input logic [7:0] asn, input logic [26:0] ppn,
                     input logic [3:0] re, input logic [3:0] we, input bit fo);
    idle();
    ins_en = 1; ins_vpn = va[42:13]; ins_asn = asn; ins_ppn = ppn;
    ins_re = re; ins_we = we; ins_fonr = fo;
    tick();
  endtask

  task automatic rdx(input bit spec);
    idle();
    rd_en = 1; rd_spec = spec;
    tick();
  endtask

  localparam logic [63:0] VA_A  = 64'h0000_0000_2468_A123;
  localparam logic [63:0] VA_B  = 64'h0000_0123_4000_0456;
  localparam logic [63:0] VA_SP = 64'hFFFF_FC12_3456_789A;
  localparam logic [63:0] VA_BADSP = 64'h0000_0400_0000_0000;
  localparam logic [63:0] VA_BAD   = 64'h8000_0000_0000_1000;

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mv[i] = 0; mvpn[i] = '0; masn[i] = '0; mppn[i] = '0;
      mre[i] = '0; mwe[i] = '0; mfo[i] = 0;
    end
    for (int i = 0; i < 8; i++) ecnt[i] = 0;
    mptr = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chkv("R12 reset valid", 64'(rsp_valid), 64'd0);
    chkv("R11 reset word", rd_data, 64'd0);
    for (int i = 0; i < 8; i++) chkv("R12 reset counter", 64'(got[i]), 64'd0);
    rst_n = 1;
    idle(); tick();

    // bypass with an otherwise malformed address
    rq(VA_BAD, 0, 1, 3, 0, 2'b10);
    rq(VA_BADSP, 1, 1, 0, 0, 2'b10);
    // malformed address carrying superpage tag: R2 precedes superpage
    rq(VA_BADSP, 0, 0, 0, 0, 2'b10);
    rq(VA_BADSP, 1, 0, 0, 0, 2'b10);
    rq(VA_BAD, 0, 0, 3, 0, 2'b00);
    // superpage window
    rq(VA_SP, 0, 0, 0, 0, 2'b10);
    rq(VA_SP, 1, 0, 0, 0, 2'b11);
    rq(VA_SP, 0, 0, 3, 0, 2'b10);
    rq(VA_SP, 1, 0, 2, 0, 2'b10);
    rq(VA_SP, 0, 0, 0, 0, 2'b01);      // window disabled -> table miss
    // table contents
    put(VA_A, 8'd5, 27'h123_4567, 4'b0011, 4'b0001, 1);
    put(VA_B, 8'd9, 27'h07A_BCDE, 4'b1111, 4'b1111, 0);
    put(VA_A, 8'd6, 27'h000_0055, 4'b1000, 4'b0000, 0);
    rq(VA_A, 0, 0, 0, 8'd5, 0);        // hit
    rq(VA_A, 0, 0, 3, 8'd5, 0);        // load refused, fault-on-read
    rq(VA_A, 1, 0, 1, 8'd5, 0);        // store refused
    rq(VA_A, 1, 0, 0, 8'd5, 0);        // store hit
    rq(VA_A, 0, 0, 0, 8'd7, 0);        // other space -> miss
    rq(VA_A, 0, 0, 3, 8'd6, 0);        // hit on second space
    rq(VA_A, 0, 0, 0, 8'd6, 0);        // load refused, no fault-on-read
    rq(VA_A, 1, 0, 3, 8'd6, 0);        // store refused
    rq(VA_B, 1, 0, 3, 8'd9, 2'b10);    // store hit with window enabled
    // indexed reads
    rdx(1); rdx(1); rdx(0); rdx(1); rdx(0); rdx(0);
    // flush and insert together: flush wins
    idle(); flush = 1; ins_en = 1; ins_vpn = VA_A[42:13]; ins_asn = 8'd5;
    ins_ppn = 27'h1; ins_re = 4'hF; ins_we = 4'hF; tick();
    rq(VA_A, 0, 0, 0, 8'd5, 0);
    chkv("R10 flush leaves miss", 64'(rsp_miss), 64'd1);
    rq(VA_B, 0, 0, 0, 8'd9, 0);
    chkv("R10 flush leaves miss", 64'(rsp_miss), 64'd1);
    put(VA_B, 8'd9, 27'h055_0AA0, 4'b0101, 4'b0001, 0);
    rq(VA_B, 0, 0, 2, 8'd9, 0);
    chkv("R10 insert then hit", 64'(rsp_hit), 64'd1);
    // fill every slot to wrap the pointer
    for (int i = 0; i < 64; i++)
      put(64'(i + 100) << 13, 8'd0, 27'(i + 1), 4'hF, 4'h0, 0);
    rq((64'(105) << 13) | 64'h10, 0, 0, 0, 8'd0, 0);
    chkv("R10 wrap hit", 64'(rsp_hit), 64'd1);
    rq((64'(105) << 13) | 64'h10, 1, 0, 0, 8'd0, 0);
    rq(VA_B, 0, 0, 2, 8'd9, 0);        // overwritten on wrap -> miss
    rdx(0); rdx(1);
    idle(); flush = 1; tick();
    rq((64'(105) << 13), 0, 0, 0, 8'd0, 0);
    chkv("R10 flush after fill", 64'(rsp_miss), 64'd1);
    idle(); tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule